// File: doc/BRIEF.md
# Reaction Time Trial Controller

This block sequences repeated trials of a simple reaction-time experiment with a limited-hold window. A single debounced response switch is the only input. Each trial begins with a quiet intertrial interval. The subject must not press during this interval; a press restarts it. A ready tone then asks the subject to close the switch. Once the switch is closed, a pseudorandom foreperiod runs. The stimulus light then comes on and the controller measures how long the subject takes to release the switch.

A release inside the limited-hold window counts as a rewarded trial. The controller pulses the feeder, adds one to the reward count and latches the measured latency. If the window runs out with the switch still closed, the controller adds one to the miss count and gives no reward. Either way, the next trial starts at once.

All timers and counters are internal. Their lengths are parameters. The block runs on one clock with a synchronous, active-high reset. The current step is brought out as a 3-bit code for a front-panel readout.

Top module: `rt_trial_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the step code becomes 0, the reward and miss counts and the latency result become 0, the tone, light and feeder are off, and the pseudorandom generator returns to `LFSR_SEED`.
- R2: In step 0 with the switch open, the controller stays in step 0 for exactly `ITI_CYC` cycles and then moves to step 1.
- R3: A closed switch at any step-0 edge moves the controller to step 2. Step 2 lasts one cycle and returns to step 0, where a full `ITI_CYC` interval starts again.
- R4: The tone is on exactly while the step code is 1. Step 1 waits with the switch open for as long as it stays open, and moves to step 3 on the first edge that sees it closed.
- R5: Step 3 lasts exactly `FP_MIN + floor(g * (FP_MAX-FP_MIN+1) / 65536)` cycles, where g is the current 16-bit generator value. The switch has no effect during step 3.
- R6: The generator is a 16-bit shift register. Its next value is `{g[14:0], g[15]^g[13]^g[12]^g[10]}`. It advances once per trial, on the edge that leaves step 6 or step 7, and holds at every other edge.
- R7: Step 4 lasts one cycle and always moves to step 5. The light is on in steps 4 and 5 only.
- R8: Step 5 lasts at most `LH_CYC` cycles. An open switch at a step-5 edge moves to step 6; this includes the last cycle of the window, where release wins over expiry. A switch still closed when the window ends moves to step 7.
- R9: In step 6 the feeder is on for one cycle. On leaving step 6, the reward count rises by one and the latency result becomes the number of cycles spent in step 5, saturated at `2^RT_W-1`.
- R10: In step 7 the feeder stays off. On leaving step 7, the miss count rises by one and the latency result keeps its previous value.
- R11: Steps 2, 6 and 7 always return to step 0 after one cycle. Step codes are 0 interval, 1 ready, 2 spurious press, 3 foreperiod, 4 stimulus, 5 hold window, 6 reward, 7 miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_closed | input | 1 | Response switch, 1 = closed |
| tone | output | 1 | Ready tone drive |
| light | output | 1 | Stimulus light drive |
| feeder | output | 1 | One-cycle reward pulse |
| hits | output | CNT_W | Rewarded-trial count |
| misses | output | CNT_W | Unrewarded-trial count |
| rt_result | output | RT_W | Latency of the last rewarded trial, in cycles |
| step | output | 3 | Current step code |

## Verification
Each step change appears one edge after the switch value that causes it. The tone, light and feeder follow the step code in the same cycle. The counts and the latency result change on the edge that leaves step 6 or step 7, so they are checked in the first cycle of the next step 0. The bench drives the switch and samples every output on falling edges. It counts how many falling-edge samples each step holds and compares that with the interval, foreperiod and hold-window lengths it works out for itself. Its generator model uses a mask-parity formulation of the same feedback taps.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [2:0] {
    ST_ITI   = 3'd0,
    ST_READY = 3'd1,
    ST_SPUR  = 3'd2,
    ST_FORE  = 3'd3,
    ST_STIM  = 3'd4,
    ST_WAIT  = 3'd5,
    ST_HIT   = 3'd6,
    ST_MISS  = 3'd7
  } step_t;

  // maximal-length 16-bit shift with taps 16,14,13,11
  function automatic logic [15:0] lfsr_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // map a 16-bit random value onto [fmin, fmin+span-1]
  function automatic logic [15:0] fp_scale(input logic [15:0] g,
                                           input logic [15:0] fmin,
                                           input logic [15:0] span);
    logic [31:0] prod;
    prod = {16'd0, g} * {16'd0, span};
    return fmin + prod[31:16];
  endfunction

endpackage

// File: rtl/rt_timer.sv
module rt_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || load)          cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  a_r2_timer_holds: assert property (@(posedge clk) disable iff (rst)
    (!load && !run) |=> $stable(cnt));
endmodule

// File: rtl/rt_lfsr.sv
module rt_lfsr import rt_pkg::*; #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output logic [15:0] value
);
  always_ff @(posedge clk) begin
    if (rst)      value <= SEED;
    else if (adv) value <= lfsr_step(value);
  end

  a_r6_never_zero: assert property (@(posedge clk) disable iff (rst)
    value != 16'd0);
endmodule

// File: rtl/rt_latency.sv
module rt_latency #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                value <= '0;
    else if (inc && value != MAXV) value <= value + 1'b1;
  end

  a_r9_saturates: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && value == MAXV) |=> value == MAXV);
endmodule

// File: rtl/rt_trial_ctrl.sv
module rt_trial_ctrl import rt_pkg::*; #(
  parameter int unsigned ITI_CYC   = 12,
  parameter int unsigned FP_MIN    = 4,
  parameter int unsigned FP_MAX    = 19,
  parameter int unsigned LH_CYC    = 20,
  parameter int unsigned RT_W      = 4,
  parameter int unsigned CNT_W     = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_closed,
  output logic             tone,
  output logic             light,
  output logic             feeder,
  output logic [CNT_W-1:0] hits,
  output logic [CNT_W-1:0] misses,
  output logic [RT_W-1:0]  rt_result,
  output logic [2:0]       step
);
  localparam int unsigned TMR_W   = 16;
  localparam logic [15:0] FP_LO   = 16'(FP_MIN);
  localparam logic [15:0] FP_SPAN = 16'(FP_MAX - FP_MIN + 1);

  step_t st, st_nxt;
  logic [15:0]     gen;
  logic [15:0]     fp_len;
  logic [RT_W-1:0] lat;
  logic iti_done, fp_done, lh_done;

  // named events
  logic ev_spur, ev_iti_end, ev_release, ev_expire, trial_end;
  assign ev_spur    = (st == ST_ITI)  &&  sw_closed;
  assign ev_iti_end = (st == ST_ITI)  && !sw_closed && iti_done;
  assign ev_release = (st == ST_WAIT) && !sw_closed;
  assign ev_expire  = (st == ST_WAIT) &&  sw_closed && lh_done;
  assign trial_end  = (st == ST_HIT)  || (st == ST_MISS);

  assign fp_len = fp_scale(gen, FP_LO, FP_SPAN);

  rt_timer #(.W(TMR_W)) u_iti (
    .clk(clk), .rst(rst), .load(st != ST_ITI), .run(st == ST_ITI),
    .load_val(TMR_W'(ITI_CYC - 1)), .done(iti_done));

  rt_timer #(.W(TMR_W)) u_fore (
    .clk(clk), .rst(rst), .load(st != ST_FORE), .run(st == ST_FORE),
    .load_val(fp_len - 16'd1), .done(fp_done));

  rt_timer #(.W(TMR_W)) u_hold (
    .clk(clk), .rst(rst), .load(st != ST_WAIT), .run(st == ST_WAIT),
    .load_val(TMR_W'(LH_CYC - 1)), .done(lh_done));

  rt_lfsr #(.SEED(LFSR_SEED)) u_gen (
    .clk(clk), .rst(rst), .adv(trial_end), .value(gen));

  rt_latency #(.W(RT_W)) u_lat (
    .clk(clk), .rst(rst), .clr(st == ST_STIM), .inc(st == ST_WAIT),
    .value(lat));

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_ITI:   if (ev_spur) st_nxt = ST_SPUR;
                else if (ev_iti_end) st_nxt = ST_READY;
      ST_READY: if (sw_closed) st_nxt = ST_FORE;
      ST_SPUR:  st_nxt = ST_ITI;
      ST_FORE:  if (fp_done) st_nxt = ST_STIM;
      ST_STIM:  st_nxt = ST_WAIT;
      ST_WAIT:  if (ev_release) st_nxt = ST_HIT;
                else if (ev_expire) st_nxt = ST_MISS;
      ST_HIT:   st_nxt = ST_ITI;
      ST_MISS:  st_nxt = ST_ITI;
      default:  st_nxt = ST_ITI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_ITI;
      hits      <= '0;
      misses    <= '0;
      rt_result <= '0;
    end else begin
      st <= st_nxt;
      if (st == ST_HIT) begin
        hits      <= hits + 1'b1;
        rt_result <= lat;
      end
      if (st == ST_MISS) misses <= misses + 1'b1;
    end
  end

  assign tone   = (st == ST_READY);
  assign light  = (st == ST_STIM) || (st == ST_WAIT);
  assign feeder = (st == ST_HIT);
  assign step   = st;

  // R2
  a_r2_iti_exit: assert property (@(posedge clk) disable iff (rst)
    ev_iti_end |=> step == 3'd1);
  // R3
  a_r3_spurious: assert property (@(posedge clk) disable iff (rst)
    ev_spur |=> step == 3'd2);
  a_r3_back: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd2) |=> (step == 3'd0) && !iti_done);
  // R4
  a_r4_tone_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(tone) |-> $past(step) == 3'd0);
  // R5
  a_r5_fore_holds: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd3 && !fp_done) |=> step == 3'd3);
  // R6
  a_r6_gen_stable: assert property (@(posedge clk) disable iff (rst)
    !trial_end |=> $stable(gen));
  // R7
  a_r7_stim_once: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd4) |=> (step == 3'd5) && light);
  // R8
  a_r8_release_wins: assert property (@(posedge clk) disable iff (rst)
    ev_release |=> feeder);
  // R9
  a_r9_hit_count: assert property (@(posedge clk) disable iff (rst)
    feeder |=> hits == $past(hits) + 1'b1);
  // R10
  a_r10_miss_count: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd7) |=> (misses == $past(misses) + 1'b1) && $stable(rt_result));
  // R11
  a_r11_return: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd6 || step == 3'd7) |=> step == 3'd0);
endmodule

// File: tb/sim_rt_trial_ctrl.sv
module sim_rt_trial_ctrl;
  localparam int ITI = 12, FPMIN = 4, FPMAX = 19, LH = 20, RTW = 4;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam int RTSAT = (1 << RTW) - 1;

  // {spurious press, switch wiggle in foreperiod, release delay k}
  localparam logic [9:0] VEC [7] = '{
    {1'b0, 1'b0, 8'd3},  {1'b1, 1'b0, 8'd0},  {1'b0, 1'b1, 8'd7},
    {1'b0, 1'b0, 8'd19}, {1'b0, 1'b0, 8'd20}, {1'b1, 1'b1, 8'd25},
    {1'b0, 1'b0, 8'd14}};

  logic clk = 1'b0, rst = 1'b1, sw = 1'b0;
  logic tone, light, feeder;
  logic [7:0] hits, misses;
  logic [RTW-1:0] rt_result;
  logic [2:0] step;
  int checks = 0, fails = 0;
  int exp_hits = 0, exp_miss = 0, exp_rt = 0;
  logic [15:0] g_model = SEED;

  always #4 clk = ~clk;

  rt_trial_ctrl #(.ITI_CYC(ITI), .FP_MIN(FPMIN), .FP_MAX(FPMAX),
    .LH_CYC(LH), .RT_W(RTW), .CNT_W(8), .LFSR_SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .sw_closed(sw), .tone(tone), .light(light),
    .feeder(feeder), .hits(hits), .misses(misses), .rt_result(rt_result),
    .step(step));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int fp_expect(input logic [15:0] g);
    return FPMIN + (int'(g) * (FPMAX - FPMIN + 1)) / 65536;
  endfunction

  function automatic logic [15:0] g_next(input logic [15:0] g);
    return {g[14:0], ^(g & 16'hB400)};
  endfunction

  task automatic run_trial(input bit spur, input bit wig, input int k);
    int n;
    if (spur) begin
      repeat (3) begin tick(); chk("R2 idle", int'(step), 0); end
      sw = 1'b1; tick();
      chk("R3 to spurious", int'(step), 2);
      sw = 1'b0; tick();
      chk("R3 back to interval", int'(step), 0);
    end
    n = 0;
    while (step == 3'd0 && n < 1000) begin n++; tick(); end
    chk("R2 interval length", n, ITI);
    chk("R4 ready step", int'(step), 1);
    chk("R4 tone on", int'(tone), 1);
    repeat (2) begin tick(); chk("R4 waits for closure", int'(step), 1); end
    sw = 1'b1; tick();
    chk("R4 to foreperiod", int'(step), 3);
    chk("R4 tone off", int'(tone), 0);
    n = 0;
    while (step == 3'd3 && n < 1000) begin
      if (wig && n == 0) sw = 1'b0;
      if (wig && n == 1) sw = 1'b1;
      n++; tick();
    end
    chk("R5 foreperiod length", n, fp_expect(g_model));
    chk("R7 stimulus step", int'(step), 4);
    chk("R7 light on", int'(light), 1);
    tick();
    chk("R7 hold window", int'(step), 5);
    n = 0;
    while (step == 3'd5 && n < 1000) begin
      if (n == k) sw = 1'b0;
      n++; tick();
    end
    chk("R7 light off", int'(light), 0);
    if (k < LH) begin
      chk("R8 window cycles", n, k + 1);
      chk("R8 reward step", int'(step), 6);
      chk("R9 feeder pulse", int'(feeder), 1);
      exp_hits++;
      exp_rt = (k + 1 > RTSAT) ? RTSAT : k + 1;
    end else begin
      chk("R8 window cycles", n, LH);
      chk("R10 miss step", int'(step), 7);
      chk("R10 no feeder", int'(feeder), 0);
      exp_miss++;
    end
    sw = 1'b0; tick();
    g_model = g_next(g_model);
    chk("R11 return to interval", int'(step), 0);
    chk("R9 feeder off", int'(feeder), 0);
    chk("R9 reward count", int'(hits), exp_hits);
    chk("R10 miss count", int'(misses), exp_miss);
    chk("R9 latency result", int'(rt_result), exp_rt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset step", int'(step), 0);
    chk("R1 reset outputs", int'({tone, light, feeder}), 0);
    chk("R1 reset counts", int'(hits) + int'(misses) + int'(rt_result), 0);
    rst = 1'b0;
    for (int i = 0; i < 7; i++)
      run_trial(VEC[i][9], VEC[i][8], int'(VEC[i][7:0]));
    // mid-trial reset inside the hold window
    n_wait();
    rst = 1'b1; tick();
    chk("R1 reset mid-trial step", int'(step), 0);
    chk("R1 reset mid-trial light", int'(light), 0);
    chk("R1 reset mid-trial counts", int'(hits) + int'(misses) + int'(rt_result), 0);
    sw = 1'b0; rst = 1'b0;
    g_model = SEED; exp_hits = 0; exp_miss = 0; exp_rt = 0;
    run_trial(1'b0, 1'b0, 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic n_wait();
    int n = 0;
    while (step != 3'd1 && n < 1000) begin n++; tick(); end
    sw = 1'b1;
    n = 0;
    while (step != 3'd5 && n < 1000) begin n++; tick(); end
    tick();
    chk("R8 still in window", int'(step), 5);
  endtask
endmodule